// File: doc/BRIEF.md
# Multi-Channel Audio Control Register Bank

This block holds every control setting of a multi-channel audio converter. A control-port front end decodes each microcontroller transfer into a one-cycle write strobe, a 3-bit register address and a data byte. The bank keeps the converter-wide settings: clock ratio, input format, mute style, power and de-emphasis. It also keeps a set of feature settings for each channel: volume, sub volume, mute, output polarity and silence-detect enable. All of these settings drive the audio datapath continuously.

Feature writes go to a target that stays set until it is changed. A select register holds a channel pointer and a broadcast flag. While the flag is clear, feature writes land in the pointed channel only. While it is set, every channel takes the same value in the same cycle. A soft-reset bit in the system register restores the defaults but leaves the clock-ratio and format fields as they are. The bank also decides which channels feed the silence-detect output, and it registers that output.

Top module: `audio_ctrl_regs`

## Requirements
- R1: Writing address 0 with data bit 7 set is a soft reset. It restores mute style soft, power on, de-emphasis 00, every volume 0, every sub volume 0, every mute 0, every polarity 0, every silence-detect enable 1 and the silence mask to all ones. The clock ratio, the format, the channel pointer and the broadcast flag keep their values, and the other data bits of that write are ignored.
- R2: After the rst_n hardware reset the outputs hold the R1 defaults, with clock ratio 00 and format 000. The channel pointer is also cleared to 0 and the broadcast flag to 0.
- R3: A write to address 0 with bit 7 clear stores the clock ratio from bits 1:0 (00 = 512fs, 01 = 384fs, 10 = 256fs, 11 = 768fs) and the format from bits 4:2. Writing address 5 stores de-emphasis from bits 1:0.
- R4: Format codes 000 to 101 are valid: I2S, LSB-justified 16, 18 and 20 bit, MSB-justified, and LSB-justified 24 bit. Codes 110 and 111 are stored as written, and fmt_invalid is 1 exactly while one of them is held.
- R5: In a non-reset write to address 0, bit 5 sets mute style (0 = soft roll-off, 1 = quick) and bit 6 sets power (0 = all channels off, 1 = all on).
- R6: A write to address 1 stores the channel pointer from bits 2:0 and the broadcast flag from bit 3. Both persist across any number of feature writes.
- R7: With the broadcast flag clear, writes to address 2 (volume, bits 7:0), address 3 (sub volume, bits 3:0) and address 4 (bit 0 mute, bit 1 invert polarity, bit 2 silence-detect enable) change only the pointed channel.
- R8: With the broadcast flag set, a write to address 2, 3 or 4 gives every channel the same new value.
- R9: Each write to address 4 sets the silence mask. The mask is all ones if the broadcast flag is set, and it is one-hot on the pointed channel otherwise.
- R10: In the cycle after an edge, silence_out is 1 exactly when at least one channel was both in the mask and silence-detect enabled at that edge, and every such channel had ch_silent high.
- R11: Writes to addresses 6 and 7 change nothing. A write is visible at the outputs just after the clock edge where wr_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, synchronous |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data byte |
| ch_silent | input | NUM_CH | Per-channel digital silence from the datapath |
| clk_ratio | output | 2 | System clock ratio code |
| in_fmt | output | 3 | Input format code |
| fmt_invalid | output | 1 | Held format code is reserved |
| mute_quick | output | 1 | Mute style: 0 soft, 1 quick |
| power_on | output | 1 | Channel power |
| deemph | output | 2 | De-emphasis setting |
| ch_vol | output | NUM_CH*VOL_W | Volume per channel, channel 0 in the low bits |
| ch_subvol | output | NUM_CH*SUB_W | Sub volume per channel |
| ch_mute | output | NUM_CH | Mute per channel |
| ch_pol_inv | output | NUM_CH | Polarity inversion per channel |
| ch_dsm | output | NUM_CH | Silence-detect enable per channel |
| ds_mask | output | NUM_CH | Channels feeding the silence output |
| silence_out | output | 1 | Registered silence-detect output |

## Verification
Every setting is a single register, so a write is due at the outputs one edge after its strobe. The bench drives a write at a falling edge and compares all outputs at the next falling edge. silence_out is due one edge after ch_silent is applied, and it is computed from the mask and enables that were held before that same write. The bench's model therefore derives the expected silence value before it applies the write.

// File: rtl/audio_ctrl_pkg.sv
package audio_ctrl_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_SYS = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEL = 3'd1;
    localparam logic [ADDR_W-1:0] A_VOL = 3'd2;
    localparam logic [ADDR_W-1:0] A_SUB = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLG = 3'd4;
    localparam logic [ADDR_W-1:0] A_DEE = 3'd5;

    localparam int SYS_SRST  = 7;
    localparam int SYS_POWER = 6;
    localparam int SYS_MQ    = 5;
    localparam int SEL_ALL   = 3;

    localparam int FLG_MUTE = 0;
    localparam int FLG_POL  = 1;
    localparam int FLG_DSM  = 2;

    typedef struct packed {
        logic [1:0] clk_ratio;
        logic [2:0] fmt;
        logic       mute_quick;
        logic       power_on;
        logic [1:0] deemph;
    } glob_t;

    localparam glob_t GLOB_DEFAULT = '{clk_ratio: 2'b00, fmt: 3'b000,
                                       mute_quick: 1'b0, power_on: 1'b1,
                                       deemph: 2'b00};
endpackage

// File: rtl/audio_ctrl_global.sv
module audio_ctrl_global
    import audio_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sys,
    input  logic              wr_dee,
    input  logic [DATA_W-1:0] wr_data,
    output glob_t             glob
);
    glob_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (wr_sys) begin
            if (wr_data[SYS_SRST]) begin
                // defaults, but clock ratio and format survive
                g_d.mute_quick = GLOB_DEFAULT.mute_quick;
                g_d.power_on   = GLOB_DEFAULT.power_on;
                g_d.deemph     = GLOB_DEFAULT.deemph;
            end else begin
                g_d.clk_ratio  = wr_data[1:0];
                g_d.fmt        = wr_data[4:2];
                g_d.mute_quick = wr_data[SYS_MQ];
                g_d.power_on   = wr_data[SYS_POWER];
            end
        end
        if (wr_dee) begin
            g_d.deemph = wr_data[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= GLOB_DEFAULT;
        else        g_q <= g_d;
    end

    assign glob = g_q;

    assert_srst_keeps_clk_fmt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sys && wr_data[SYS_SRST]) |=> ($stable(g_q.clk_ratio) && $stable(g_q.fmt)));

    assert_srst_power_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sys && wr_data[SYS_SRST]) |=> (g_q.power_on && !g_q.mute_quick));
endmodule

// File: rtl/audio_ctrl_chan.sv
module audio_ctrl_chan #(
    parameter int VOL_W = 8,
    parameter int SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             soft_rst,
    input  logic             wr_vol,
    input  logic             wr_sub,
    input  logic             wr_flg,
    input  logic [VOL_W-1:0] vol_in,
    input  logic [SUB_W-1:0] sub_in,
    input  logic [2:0]       flg_in,
    output logic [VOL_W-1:0] vol,
    output logic [SUB_W-1:0] subvol,
    output logic             mute,
    output logic             pol_inv,
    output logic             dsm
);
    import audio_ctrl_pkg::*;

    typedef struct packed {
        logic [VOL_W-1:0] vol;
        logic [SUB_W-1:0] sub;
        logic             mute;
        logic             pol;
        logic             dsm;
    } chan_t;

    localparam chan_t CHAN_DEFAULT = '{vol: '0, sub: '0, mute: 1'b0,
                                       pol: 1'b0, dsm: 1'b1};

    chan_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (soft_rst) begin
            c_d = CHAN_DEFAULT;
        end else if (hit) begin
            if (wr_vol) c_d.vol = vol_in;
            if (wr_sub) c_d.sub = sub_in;
            if (wr_flg) begin
                c_d.mute = flg_in[FLG_MUTE];
                c_d.pol  = flg_in[FLG_POL];
                c_d.dsm  = flg_in[FLG_DSM];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= CHAN_DEFAULT;
        else        c_q <= c_d;
    end

    assign vol     = c_q.vol;
    assign subvol  = c_q.sub;
    assign mute    = c_q.mute;
    assign pol_inv = c_q.pol;
    assign dsm     = c_q.dsm;

    assert_untargeted_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !soft_rst) |=> ($stable(c_q.vol) && $stable(c_q.sub) && $stable(c_q.mute)
                                 && $stable(c_q.pol) && $stable(c_q.dsm)));
endmodule

// File: rtl/audio_ctrl_silence.sv
module audio_ctrl_silence #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_flg,
    input  logic              soft_rst,
    input  logic              bcast,
    input  logic [CH_W-1:0]   ptr,
    input  logic [NUM_CH-1:0] dsm_vec,
    input  logic [NUM_CH-1:0] silent_vec,
    output logic [NUM_CH-1:0] mask,
    output logic              silence_out
);
    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic              sil;
    } sil_t;

    sil_t s_d, s_q;
    logic [NUM_CH-1:0] watched;

    always_comb begin
        s_d     = s_q;
        watched = s_q.mask & dsm_vec;
        s_d.sil = (|watched) && ((watched & ~silent_vec) == '0);
        if (soft_rst) begin
            s_d.mask = '1;
        end else if (wr_flg) begin
            if (bcast) begin
                s_d.mask = '1;
            end else begin
                s_d.mask = '0;
                for (int i = 0; i < NUM_CH; i++) begin
                    if (ptr == CH_W'(i)) s_d.mask[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{mask: '1, sil: 1'b0};
        else        s_q <= s_d;
    end

    assign mask        = s_q.mask;
    assign silence_out = s_q.sil;

    assert_mask_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mask == '1) || ($countones(s_q.mask) == 1));

    assert_sil_needs_watch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mask == '0) |=> !s_q.sil);
endmodule

// File: rtl/audio_ctrl_regs.sv
module audio_ctrl_regs
    import audio_ctrl_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int VOL_W  = 8,
    parameter int SUB_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [2:0]              wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [NUM_CH-1:0]       ch_silent,
    output logic [1:0]              clk_ratio,
    output logic [2:0]              in_fmt,
    output logic                    fmt_invalid,
    output logic                    mute_quick,
    output logic                    power_on,
    output logic [1:0]              deemph,
    output logic [NUM_CH*VOL_W-1:0] ch_vol,
    output logic [NUM_CH*SUB_W-1:0] ch_subvol,
    output logic [NUM_CH-1:0]       ch_mute,
    output logic [NUM_CH-1:0]       ch_pol_inv,
    output logic [NUM_CH-1:0]       ch_dsm,
    output logic [NUM_CH-1:0]       ds_mask,
    output logic                    silence_out
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [CH_W-1:0] ptr;
        logic            bcast;
    } sel_t;

    sel_t sel_d, sel_q;

    logic wr_sys, wr_sel, wr_vol, wr_sub, wr_flg, wr_dee, soft_rst;
    glob_t glob;

    always_comb begin
        wr_sys   = wr_en && (wr_addr == A_SYS);
        wr_sel   = wr_en && (wr_addr == A_SEL);
        wr_vol   = wr_en && (wr_addr == A_VOL);
        wr_sub   = wr_en && (wr_addr == A_SUB);
        wr_flg   = wr_en && (wr_addr == A_FLG);
        wr_dee   = wr_en && (wr_addr == A_DEE);
        soft_rst = wr_sys && wr_data[SYS_SRST];

        sel_d = sel_q;
        if (wr_sel) begin
            sel_d.ptr   = wr_data[CH_W-1:0];
            sel_d.bcast = wr_data[SEL_ALL];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '{ptr: '0, bcast: 1'b0};
        else        sel_q <= sel_d;
    end

    audio_ctrl_global u_global (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sys  (wr_sys),
        .wr_dee  (wr_dee),
        .wr_data (wr_data),
        .glob    (glob)
    );

    assign clk_ratio   = glob.clk_ratio;
    assign in_fmt      = glob.fmt;
    assign fmt_invalid = glob.fmt[2] & glob.fmt[1];
    assign mute_quick  = glob.mute_quick;
    assign power_on    = glob.power_on;
    assign deemph      = glob.deemph;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic hit_i;
        assign hit_i = sel_q.bcast || (sel_q.ptr == CH_W'(i));

        audio_ctrl_chan #(.VOL_W(VOL_W), .SUB_W(SUB_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit_i),
            .soft_rst (soft_rst),
            .wr_vol   (wr_vol),
            .wr_sub   (wr_sub),
            .wr_flg   (wr_flg),
            .vol_in   (wr_data[VOL_W-1:0]),
            .sub_in   (wr_data[SUB_W-1:0]),
            .flg_in   (wr_data[2:0]),
            .vol      (ch_vol[i*VOL_W +: VOL_W]),
            .subvol   (ch_subvol[i*SUB_W +: SUB_W]),
            .mute     (ch_mute[i]),
            .pol_inv  (ch_pol_inv[i]),
            .dsm      (ch_dsm[i])
        );
    end

    audio_ctrl_silence #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_silence (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_flg      (wr_flg),
        .soft_rst    (soft_rst),
        .bcast       (sel_q.bcast),
        .ptr         (sel_q.ptr),
        .dsm_vec     (ch_dsm),
        .silent_vec  (ch_silent),
        .mask        (ds_mask),
        .silence_out (silence_out)
    );

    assert_select_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(sel_q));

    assert_bcast_vol_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vol && sel_q.bcast) |=> (ch_vol == {NUM_CH{$past(wr_data[VOL_W-1:0])}}));

    assert_fmt_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sys && !wr_data[SYS_SRST] && (wr_data[4:3] == 2'b11)) |=> fmt_invalid);
endmodule

// File: tb/audio_ctrl_regs_bench.sv
module audio_ctrl_regs_bench;
    localparam int NUM_CH = 8;
    localparam int VOL_W  = 8;
    localparam int SUB_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [NUM_CH-1:0] ch_silent = '0;
    logic [1:0] clk_ratio;
    logic [2:0] in_fmt;
    logic fmt_invalid, mute_quick, power_on, silence_out;
    logic [1:0] deemph;
    logic [NUM_CH*VOL_W-1:0] ch_vol;
    logic [NUM_CH*SUB_W-1:0] ch_subvol;
    logic [NUM_CH-1:0] ch_mute, ch_pol_inv, ch_dsm, ds_mask;

    always #2.5 clk = ~clk;

    audio_ctrl_regs #(.NUM_CH(NUM_CH), .VOL_W(VOL_W), .SUB_W(SUB_W)) u_audio_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ch_silent(ch_silent), .clk_ratio(clk_ratio), .in_fmt(in_fmt),
        .fmt_invalid(fmt_invalid), .mute_quick(mute_quick), .power_on(power_on),
        .deemph(deemph), .ch_vol(ch_vol), .ch_subvol(ch_subvol), .ch_mute(ch_mute),
        .ch_pol_inv(ch_pol_inv), .ch_dsm(ch_dsm), .ds_mask(ds_mask),
        .silence_out(silence_out)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model
    logic [1:0] m_clk, m_dee;
    logic [2:0] m_fmt, m_ptr;
    logic m_mq, m_pw, m_all, m_sil;
    logic [VOL_W-1:0] m_vol [NUM_CH];
    logic [SUB_W-1:0] m_sub [NUM_CH];
    logic [NUM_CH-1:0] m_mute, m_pol, m_dsm, m_mask;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model_defaults(input bit hard);
        if (hard) begin
            m_clk = 2'b00; m_fmt = 3'b000; m_ptr = '0; m_all = 1'b0; m_sil = 1'b0;
        end
        m_mq = 1'b0; m_pw = 1'b1; m_dee = 2'b00;
        for (int i = 0; i < NUM_CH; i++) begin
            m_vol[i] = '0; m_sub[i] = '0;
        end
        m_mute = '0; m_pol = '0; m_dsm = '1; m_mask = '1;
    endfunction

    function automatic logic exp_silence(input logic [NUM_CH-1:0] sil);
        logic [NUM_CH-1:0] w;
        w = m_mask & m_dsm;
        return (|w) && ((w & ~sil) == '0);
    endfunction

    function automatic void model_write(input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd0: if (d[7]) model_defaults(1'b0);
                  else begin
                      m_clk = d[1:0]; m_fmt = d[4:2]; m_mq = d[5]; m_pw = d[6];
                  end
            3'd1: begin m_ptr = d[2:0]; m_all = d[3]; end
            3'd2: for (int i = 0; i < NUM_CH; i++)
                      if (m_all || m_ptr == 3'(i)) m_vol[i] = d[VOL_W-1:0];
            3'd3: for (int i = 0; i < NUM_CH; i++)
                      if (m_all || m_ptr == 3'(i)) m_sub[i] = d[SUB_W-1:0];
            3'd4: begin
                for (int i = 0; i < NUM_CH; i++)
                    if (m_all || m_ptr == 3'(i)) begin
                        m_mute[i] = d[0]; m_pol[i] = d[1]; m_dsm[i] = d[2];
                    end
                m_mask = m_all ? '1 : (NUM_CH'(1) << m_ptr);
            end
            3'd5: m_dee = d[1:0];
            default: ;
        endcase
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " R3 clk_ratio"}, 64'(clk_ratio), 64'(m_clk));
        chk({tag, " R3 in_fmt"}, 64'(in_fmt), 64'(m_fmt));
        chk({tag, " R4 fmt_invalid"}, 64'(fmt_invalid), 64'(m_fmt[2] & m_fmt[1]));
        chk({tag, " R5 mute_quick"}, 64'(mute_quick), 64'(m_mq));
        chk({tag, " R5 power_on"}, 64'(power_on), 64'(m_pw));
        chk({tag, " R3 deemph"}, 64'(deemph), 64'(m_dee));
        for (int i = 0; i < NUM_CH; i++) begin
            chk({tag, " R7 vol"}, 64'(ch_vol[i*VOL_W +: VOL_W]), 64'(m_vol[i]));
            chk({tag, " R7 subvol"}, 64'(ch_subvol[i*SUB_W +: SUB_W]), 64'(m_sub[i]));
        end
        chk({tag, " R8 mute"}, 64'(ch_mute), 64'(m_mute));
        chk({tag, " R8 pol"}, 64'(ch_pol_inv), 64'(m_pol));
        chk({tag, " R8 dsm"}, 64'(ch_dsm), 64'(m_dsm));
        chk({tag, " R9 mask"}, 64'(ds_mask), 64'(m_mask));
        chk({tag, " R10 silence"}, 64'(silence_out), 64'(m_sil));
    endtask

    // called at a falling edge; checks at the next falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d,
                      input logic [NUM_CH-1:0] sil, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d; ch_silent = sil;
        m_sil = exp_silence(sil);
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
        check_all(tag);
    endtask

    initial begin
        void'($urandom(32'h0A11_C0DE));
        model_defaults(1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R2 hw reset");

        // R3 R5: clock, format, mute style, power
        wr(3'd0, 8'b0_1_1_011_10, '0, "R3 sys write");
        wr(3'd5, 8'h03, '0, "R3 deemph");
        // R4 reserved formats
        wr(3'd0, 8'b0_0_0_110_01, '0, "R4 fmt 110");
        wr(3'd0, 8'b0_0_0_111_11, '0, "R4 fmt 111");
        wr(3'd0, 8'b0_1_0_101_00, '0, "R4 fmt 101");
        // R6 R7: sticky single channel
        wr(3'd1, 8'h03, '0, "R6 select 3");
        wr(3'd2, 8'hA5, '0, "R7 vol ch3");
        wr(3'd3, 8'hF9, '0, "R7 sub ch3");
        wr(3'd4, 8'h03, '0, "R7 flags ch3");
        // R9 R10 silence on one channel
        wr(3'd4, 8'h04, 8'h08, "R9 onehot mask");
        wr(3'd2, 8'h11, 8'h08, "R10 silent ch3");
        wr(3'd2, 8'h12, 8'hF7, "R10 ch3 not silent");
        // R8 broadcast
        wr(3'd1, 8'h0D, '0, "R8 select all");
        wr(3'd2, 8'h3C, '0, "R8 vol all");
        wr(3'd4, 8'h06, '0, "R8 flags all");
        wr(3'd4, 8'h00, 8'hFF, "R10 all disabled");
        wr(3'd3, 8'h07, 8'hFF, "R10 none watched");
        // R11 ignored addresses
        wr(3'd6, 8'hFF, '0, "R11 addr6");
        wr(3'd7, 8'h80, '0, "R11 addr7");
        // R1 soft reset keeps clock and format
        wr(3'd0, 8'b0_0_1_100_11, '0, "R1 setup");
        wr(3'd0, 8'hFF, 8'hFF, "R1 soft reset");
        wr(3'd0, 8'h00, 8'hFF, "R1 defaults silence");
        wr(3'd2, 8'h44, '0, "R1 pointer kept");

        // random traffic
        for (int n = 0; n < 600; n++) begin
            logic [2:0] a;
            logic [7:0] d;
            logic [NUM_CH-1:0] s;
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom);
            if (a == 3'd0 && ($urandom_range(0, 3) != 0)) d[7] = 1'b0;
            s = ($urandom_range(0, 1) == 1) ? '1 : NUM_CH'($urandom);
            wr(a, d, s, "R11 random");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule